// File: doc/BRIEF.md
# Register Value Cache with Dead-Value Hints

This block is a small tagged store of register values that sits next to the execution units, in front of a larger and more costly backing register file. Each entry is addressed by an active-thread slot number and an architectural register number. Every slot owns a fixed group of entries. Results written by the execution units land in the cache. Operand reads first pass through a registered tag-check stage. On a hit the cached word is returned. On a miss the word is fetched from the backing file and kept as a clean entry.

A result write can carry a hint that the value will never be read from the backing file again. A dirty entry that is pushed out by a new allocation is copied back to the backing file unless it carries that hint. When the scheduler removes a thread from its active pool, a flush of that thread's slot walks the group one entry per cycle. The walk copies back every live dirty value, then empties the group and reports completion. While a miss or a flush is in progress, the block raises a stall that holds off all of its request inputs.

Top module: `rf_cache`

## Requirements
- R1: After reset, rd_ack_o, stall_o, bf_rd_o, bf_wr_o and flush_done_o are low and every entry is invalid, so the first read of any register misses.
- R2: A read accepted at rising edge n (rd_req_i high, stall_o low) that hits returns rd_ack_o high with the cached word during the cycle after edge n+1, and bf_rd_o stays low.
- R3: A read that misses raises bf_rd_o for exactly the one cycle after edge n, carrying its slot and register. stall_o is high in that cycle and the next. The word on bf_rd_data_i in the cycle after bf_rd_o is returned with rd_ack_o after edge n+2 and is kept as a clean entry, so a later read of it hits.
- R4: An accepted result write stores its word without reading the backing file and marks the entry dirty. A write to a register already cached updates that entry in place and evicts nothing.
- R5: Each slot holds SLOT_ENTRIES entries replaced in FIFO order. Every allocation (a write miss or a read fill) takes the oldest entry of its slot. If the victim is valid, dirty and not marked dead, bf_wr_o is high in the allocating cycle with the victim's slot, register and word.
- R6: Evicting a clean entry, or a dirty entry whose write carried wr_dead_i, drives no backing write, and the backing file keeps its earlier word.
- R7: flush_i accepted at edge n makes the block stall and visit the slot's entries in index order, one per cycle, writing back each valid, dirty, not-dead entry. flush_done_o is high for one cycle after edge n+SLOT_ENTRIES, after which the slot's group is empty. Other slots are untouched.
- R8: When a result write to the same slot and register is presented in the cycle a read sits in the tag-check stage, the read hits and returns the newly written word, with no backing read.
- R9: While stall_o is high, rd_req_i, wr_en_i and flush_i have no effect.
- R10: The same register number in different slots names independent entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Operand read request |
| rd_slot_i | input | SLOT_W | Slot of the read |
| rd_reg_i | input | REG_W | Register number of the read |
| rd_ack_o | output | 1 | Read data valid |
| rd_data_o | output | DATA_W | Read data |
| stall_o | output | 1 | Holds off all request inputs |
| wr_en_i | input | 1 | Result write |
| wr_slot_i | input | SLOT_W | Slot of the write |
| wr_reg_i | input | REG_W | Register number of the write |
| wr_data_i | input | DATA_W | Result word |
| wr_dead_i | input | 1 | Value need not reach the backing file |
| flush_i | input | 1 | Start slot flush |
| flush_slot_i | input | SLOT_W | Slot to flush |
| flush_done_o | output | 1 | One-cycle flush completion |
| bf_rd_o | output | 1 | Backing-file read strobe |
| bf_rd_slot_o | output | SLOT_W | Backing read slot |
| bf_rd_reg_o | output | REG_W | Backing read register |
| bf_rd_data_i | input | DATA_W | Backing read word, one cycle after strobe |
| bf_wr_o | output | 1 | Backing-file write strobe |
| bf_wr_slot_o | output | SLOT_W | Backing write slot |
| bf_wr_reg_o | output | REG_W | Backing write register |
| bf_wr_data_o | output | DATA_W | Backing write word |

## Verification
A hit answers two rising edges after the read is accepted, and a miss answers three. The bench presents each read at a falling edge and counts the falling edges until rd_ack_o appears, so it checks the exact latency as well as the word. Eviction writebacks are combinational in the allocating cycle, so the bench samples bf_wr_o one nanosecond after it drives the write. flush_done_o is due SLOT_ENTRIES edges after acceptance, so the bench expects it on the falling edge after that count and low on the one after. Writebacks are also checked indirectly: a later miss must return from the bench's backing memory exactly the word that was, or was not, copied back.

// File: rtl/rf_cache_pkg.sv
package rf_cache_pkg;
  typedef enum logic [1:0] {
    RC_IDLE  = 2'd0,
    RC_WAIT  = 2'd1,
    RC_FLUSH = 2'd2
  } rc_state_e;
endpackage

// File: rtl/rf_cache_match.sv
module rf_cache_match #(
  parameter int N     = 6,
  parameter int TAG_W = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && tag_i[i] == key_i) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rf_cache_fifo.sv
module rf_cache_fifo #(
  parameter int NUM_SLOTS = 4,
  parameter int DEPTH     = 6,
  parameter int SLOT_W    = 2,
  parameter int IDX_W     = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             adv_i,
  input  logic [SLOT_W-1:0]                adv_slot_i,
  input  logic                             clr_i,
  input  logic [SLOT_W-1:0]                clr_slot_i,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]  ptr_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [IDX_W-1:0] ptr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= '0;
      end else if (clr_i && clr_slot_i == SLOT_W'(s)) begin
        ptr_q <= '0;
      end else if (adv_i && adv_slot_i == SLOT_W'(s)) begin
        ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
    assign ptr_o[s] = ptr_q;
  end
endmodule

// File: rtl/rf_cache.sv
module rf_cache #(
  parameter int NUM_SLOTS    = 4,
  parameter int SLOT_ENTRIES = 6,
  parameter int REG_W        = 6,
  parameter int DATA_W       = 32,
  parameter int SLOT_W       = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [REG_W-1:0]  rd_reg_i,
  output logic              rd_ack_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              stall_o,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [REG_W-1:0]  wr_reg_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_dead_i,
  input  logic              flush_i,
  input  logic [SLOT_W-1:0] flush_slot_i,
  output logic              flush_done_o,
  output logic              bf_rd_o,
  output logic [SLOT_W-1:0] bf_rd_slot_o,
  output logic [REG_W-1:0]  bf_rd_reg_o,
  input  logic [DATA_W-1:0] bf_rd_data_i,
  output logic              bf_wr_o,
  output logic [SLOT_W-1:0] bf_wr_slot_o,
  output logic [REG_W-1:0]  bf_wr_reg_o,
  output logic [DATA_W-1:0] bf_wr_data_o
);
  import rf_cache_pkg::*;

  localparam int IDX_W   = $clog2(SLOT_ENTRIES);
  localparam int NUM_ENT = NUM_SLOTS * SLOT_ENTRIES;
  localparam int ENT_W   = $clog2(NUM_ENT);

  function automatic logic [ENT_W-1:0] ent_of(logic [SLOT_W-1:0] s, logic [IDX_W-1:0] k);
    return ENT_W'(s) * ENT_W'(SLOT_ENTRIES) + ENT_W'(k);
  endfunction

  // entry storage and flags
  logic [DATA_W-1:0]  data_q [NUM_ENT];
  logic [REG_W-1:0]   tag_q  [NUM_ENT];
  logic [NUM_ENT-1:0] valid_q, dirty_q, dead_q;

  rc_state_e          st_q;
  logic               stg_v_q;
  logic [SLOT_W-1:0]  stg_slot_q;
  logic [REG_W-1:0]   stg_reg_q;
  logic [SLOT_W-1:0]  fl_slot_q;
  logic [IDX_W-1:0]   fl_idx_q;
  logic               ack_q, done_q;
  logic [DATA_W-1:0]  rdat_q;

  logic [NUM_SLOTS-1:0][IDX_W-1:0] ptr;

  // per-slot group views for the two lookups
  logic [SLOT_ENTRIES-1:0]            rg_v, wg_v;
  logic [SLOT_ENTRIES-1:0][REG_W-1:0] rg_tag, wg_tag;

  for (genvar g = 0; g < SLOT_ENTRIES; g++) begin : g_grp
    assign rg_v[g]   = valid_q[ent_of(stg_slot_q, IDX_W'(g))];
    assign rg_tag[g] = tag_q[ent_of(stg_slot_q, IDX_W'(g))];
    assign wg_v[g]   = valid_q[ent_of(wr_slot_i, IDX_W'(g))];
    assign wg_tag[g] = tag_q[ent_of(wr_slot_i, IDX_W'(g))];
  end

  logic             rm_hit, wm_hit;
  logic [IDX_W-1:0] rm_idx, wm_idx;

  rf_cache_match #(.N(SLOT_ENTRIES), .TAG_W(REG_W), .IDX_W(IDX_W)) u_rd_match (
    .valid_i(rg_v), .tag_i(rg_tag), .key_i(stg_reg_q), .hit_o(rm_hit), .idx_o(rm_idx)
  );

  rf_cache_match #(.N(SLOT_ENTRIES), .TAG_W(REG_W), .IDX_W(IDX_W)) u_wr_match (
    .valid_i(wg_v), .tag_i(wg_tag), .key_i(wr_reg_i), .hit_o(wm_hit), .idx_o(wm_idx)
  );

  // tag-check stage
  logic tag_chk, fwd, tag_miss, wr_go, fl_go, fl_last;
  assign tag_chk  = stg_v_q && (st_q == RC_IDLE);
  assign fwd      = wr_en_i && (wr_slot_i == stg_slot_q) && (wr_reg_i == stg_reg_q);
  assign tag_miss = tag_chk && !rm_hit && !fwd;
  assign stall_o  = (st_q != RC_IDLE) || tag_miss;
  assign wr_go    = wr_en_i && !stall_o;
  assign fl_go    = flush_i && !stall_o;
  assign fl_last  = (fl_idx_q == IDX_W'(SLOT_ENTRIES - 1));

  logic [ENT_W-1:0] r_ent, w_vic, w_ent, f_ent, fl_ent;
  assign r_ent  = ent_of(stg_slot_q, rm_idx);
  assign w_vic  = ent_of(wr_slot_i, ptr[wr_slot_i]);
  assign w_ent  = wm_hit ? ent_of(wr_slot_i, wm_idx) : w_vic;
  assign f_ent  = ent_of(stg_slot_q, ptr[stg_slot_q]);
  assign fl_ent = ent_of(fl_slot_q, fl_idx_q);

  // entry write selection
  logic              ent_we, ent_dirty, ent_dead;
  logic [ENT_W-1:0]  ent_sel;
  logic [DATA_W-1:0] ent_wdata;
  logic [REG_W-1:0]  ent_wtag;
  logic              alloc;
  logic [SLOT_W-1:0] alloc_slot;

  always_comb begin
    ent_we     = 1'b0;
    ent_sel    = w_ent;
    ent_wdata  = wr_data_i;
    ent_wtag   = wr_reg_i;
    ent_dirty  = 1'b1;
    ent_dead   = wr_dead_i;
    alloc      = 1'b0;
    alloc_slot = wr_slot_i;
    if (st_q == RC_IDLE && wr_go) begin
      ent_we = 1'b1;
      alloc  = !wm_hit;
    end else if (st_q == RC_WAIT) begin
      ent_we     = 1'b1;
      ent_sel    = f_ent;
      ent_wdata  = bf_rd_data_i;
      ent_wtag   = stg_reg_q;
      ent_dirty  = 1'b0;
      ent_dead   = 1'b0;
      alloc      = 1'b1;
      alloc_slot = stg_slot_q;
    end
  end

  // backing-file write source, one per state
  always_comb begin
    bf_wr_o      = 1'b0;
    bf_wr_slot_o = wr_slot_i;
    bf_wr_reg_o  = tag_q[w_vic];
    bf_wr_data_o = data_q[w_vic];
    case (st_q)
      RC_IDLE: begin
        bf_wr_o = wr_go && !wm_hit && valid_q[w_vic] && dirty_q[w_vic] && !dead_q[w_vic];
      end
      RC_WAIT: begin
        bf_wr_o      = valid_q[f_ent] && dirty_q[f_ent] && !dead_q[f_ent];
        bf_wr_slot_o = stg_slot_q;
        bf_wr_reg_o  = tag_q[f_ent];
        bf_wr_data_o = data_q[f_ent];
      end
      RC_FLUSH: begin
        bf_wr_o      = valid_q[fl_ent] && dirty_q[fl_ent] && !dead_q[fl_ent];
        bf_wr_slot_o = fl_slot_q;
        bf_wr_reg_o  = tag_q[fl_ent];
        bf_wr_data_o = data_q[fl_ent];
      end
      default: bf_wr_o = 1'b0;
    endcase
  end

  assign bf_rd_o      = tag_miss;
  assign bf_rd_slot_o = stg_slot_q;
  assign bf_rd_reg_o  = stg_reg_q;

  rf_cache_fifo #(
    .NUM_SLOTS(NUM_SLOTS), .DEPTH(SLOT_ENTRIES), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (alloc),
    .adv_slot_i (alloc_slot),
    .clr_i      (st_q == RC_FLUSH && fl_last),
    .clr_slot_i (fl_slot_q),
    .ptr_o      (ptr)
  );

  always_ff @(posedge clk_i) begin
    if (ent_we) begin
      data_q[ent_sel] <= ent_wdata;
      tag_q[ent_sel]  <= ent_wtag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      dead_q  <= '0;
    end else if (ent_we) begin
      valid_q[ent_sel] <= 1'b1;
      dirty_q[ent_sel] <= ent_dirty;
      dead_q[ent_sel]  <= ent_dead;
    end else if (st_q == RC_FLUSH && fl_last) begin
      for (int k = 0; k < SLOT_ENTRIES; k++) begin
        valid_q[ent_of(fl_slot_q, IDX_W'(k))] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= RC_IDLE;
      stg_v_q    <= 1'b0;
      stg_slot_q <= '0;
      stg_reg_q  <= '0;
      fl_slot_q  <= '0;
      fl_idx_q   <= '0;
      ack_q      <= 1'b0;
      done_q     <= 1'b0;
      rdat_q     <= '0;
    end else begin
      ack_q  <= 1'b0;
      done_q <= 1'b0;
      if (!stall_o) begin
        stg_v_q    <= rd_req_i;
        stg_slot_q <= rd_slot_i;
        stg_reg_q  <= rd_reg_i;
      end
      case (st_q)
        RC_IDLE: begin
          if (tag_chk && !tag_miss) begin
            ack_q  <= 1'b1;
            rdat_q <= fwd ? wr_data_i : data_q[r_ent];
          end
          if (tag_miss) begin
            st_q <= RC_WAIT;
          end else if (fl_go) begin
            st_q      <= RC_FLUSH;
            fl_slot_q <= flush_slot_i;
            fl_idx_q  <= '0;
          end
        end
        RC_WAIT: begin
          ack_q   <= 1'b1;
          rdat_q  <= bf_rd_data_i;
          stg_v_q <= 1'b0;
          st_q    <= RC_IDLE;
        end
        RC_FLUSH: begin
          if (fl_last) begin
            st_q   <= RC_IDLE;
            done_q <= 1'b1;
          end else begin
            fl_idx_q <= fl_idx_q + 1'b1;
          end
        end
        default: st_q <= RC_IDLE;
      endcase
    end
  end

  assign rd_ack_o     = ack_q;
  assign rd_data_o    = rdat_q;
  assign flush_done_o = done_q;
endmodule

// File: rtl/rf_cache_chk.sv
module rf_cache_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_o,
  input logic              bf_rd_o,
  input logic              bf_wr_o,
  input logic              rd_ack_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [DATA_W-1:0] bf_rd_data_i,
  input logic              flush_done_o
);
  a_r3_rd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bf_rd_o |=> !bf_rd_o);

  a_r3_rd_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bf_rd_o |-> stall_o);

  a_r3_fill_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bf_rd_o, 2) |-> (rd_ack_o && rd_data_o == $past(bf_rd_data_i)));

  a_r5_port_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bf_rd_o && bf_wr_o));

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |=> !flush_done_o);

  a_r7_done_after_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flush_done_o) |-> $past(stall_o));
endmodule

bind rf_cache rf_cache_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_o      (stall_o),
  .bf_rd_o      (bf_rd_o),
  .bf_wr_o      (bf_wr_o),
  .rd_ack_o     (rd_ack_o),
  .rd_data_o    (rd_data_o),
  .bf_rd_data_i (bf_rd_data_i),
  .flush_done_o (flush_done_o)
);

// File: tb/tb_rf_cache.sv
module tb_rf_cache;
  localparam int NS = 4, NE = 6, RW = 6, DW = 32, SW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          rd_req = 0, wr_en = 0, wr_dead = 0, flush = 0;
  logic [SW-1:0] rd_slot = 0, wr_slot = 0, flush_slot = 0;
  logic [RW-1:0] rd_reg = 0, wr_reg = 0;
  logic [DW-1:0] wr_data = 0;
  logic          rd_ack, stall, flush_done, bf_rd, bf_wr;
  logic [DW-1:0] rd_data, bf_wdata, bf_rdata;
  logic [SW-1:0] bf_rslot, bf_wslot;
  logic [RW-1:0] bf_rreg, bf_wreg;

  rf_cache #(.NUM_SLOTS(NS), .SLOT_ENTRIES(NE), .REG_W(RW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_req_i(rd_req), .rd_slot_i(rd_slot), .rd_reg_i(rd_reg),
    .rd_ack_o(rd_ack), .rd_data_o(rd_data), .stall_o(stall),
    .wr_en_i(wr_en), .wr_slot_i(wr_slot), .wr_reg_i(wr_reg), .wr_data_i(wr_data),
    .wr_dead_i(wr_dead), .flush_i(flush), .flush_slot_i(flush_slot),
    .flush_done_o(flush_done),
    .bf_rd_o(bf_rd), .bf_rd_slot_o(bf_rslot), .bf_rd_reg_o(bf_rreg), .bf_rd_data_i(bf_rdata),
    .bf_wr_o(bf_wr), .bf_wr_slot_o(bf_wslot), .bf_wr_reg_o(bf_wreg), .bf_wr_data_o(bf_wdata)
  );

  function automatic logic [DW-1:0] init_word(int s, int r);
    return 32'hB0B0_0000 | DW'(s << 8) | DW'(r);
  endfunction

  // backing file model: one-cycle read latency
  logic [DW-1:0] bmem [NS][64];
  initial begin
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < 64; r++) bmem[s][r] = init_word(s, r);
  end
  always @(posedge clk) begin
    if (bf_wr) bmem[bf_wslot][bf_wreg] <= bf_wdata;
    bf_rdata <= bf_rd ? bmem[bf_rslot][bf_rreg] : '0;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(int s, int r, logic [DW-1:0] d, bit dead,
                          output bit ev, output logic [RW-1:0] ev_reg, output logic [DW-1:0] ev_d);
    @(negedge clk);
    wr_en = 1; wr_slot = SW'(s); wr_reg = RW'(r); wr_data = d; wr_dead = dead;
    #1;
    ev = bf_wr; ev_reg = bf_wreg; ev_d = bf_wdata;
    @(negedge clk);
    wr_en = 0; wr_dead = 0;
  endtask

  task automatic do_read(int s, int r, output logic [DW-1:0] d, output int lat,
                         output bit missed, output logic [RW-1:0] miss_reg);
    @(negedge clk);
    rd_req = 1; rd_slot = SW'(s); rd_reg = RW'(r);
    lat = 0; missed = 0; d = '0; miss_reg = '0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      rd_req = 0;
      if (bf_rd) begin missed = 1; miss_reg = bf_rreg; end
      if (rd_ack) begin d = rd_data; lat = c; break; end
    end
  endtask

  localparam logic [39:0] VEC_TAB [5] = '{
    {2'd1, 6'd7,  32'hA100_0007},
    {2'd2, 6'd7,  32'hA200_0007},
    {2'd1, 6'd33, 32'hA100_0021},
    {2'd2, 6'd63, 32'hA200_003F},
    {2'd1, 6'd0,  32'hA100_0000}
  };

  function automatic logic [DW-1:0] d3(int r);
    return 32'h3300_0000 | DW'(r);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit ev, miss;
    logic [RW-1:0] evr, mr;
    logic [DW-1:0] evd, d;
    int lat, evc, wcnt, flat;
    logic [RW-1:0] first_reg;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk("R1", "idle outputs", {27'd0, rd_ack, stall, bf_rd, bf_wr, flush_done}, '0);

    // R1/R3: cold read misses, fetches, and returns the backing word
    do_read(0, 3, d, lat, miss, mr);
    chk("R1", "cold read misses", 32'(miss), 32'd1);
    chk("R3", "miss register", 32'(mr), 32'd3);
    chk("R3", "miss latency", lat, 3);
    chk("R3", "miss data", d, init_word(0, 3));
    // R2: refetch hits
    do_read(0, 3, d, lat, miss, mr);
    chk("R2", "hit no backing read", 32'(miss), 32'd0);
    chk("R2", "hit latency", lat, 2);
    chk("R2", "hit data", d, init_word(0, 3));

    // R4/R10: write then read, table driven
    for (int i = 0; i < 5; i++) begin
      do_write(int'(VEC_TAB[i][39:38]), int'(VEC_TAB[i][37:32]), VEC_TAB[i][31:0], 0, ev, evr, evd);
      do_read(int'(VEC_TAB[i][39:38]), int'(VEC_TAB[i][37:32]), d, lat, miss, mr);
      chk("R4", "written word read back", d, VEC_TAB[i][31:0]);
      chk("R4", "no backing read on written reg", {31'd0, miss}, 32'd0);
    end
    do_read(1, 7, d, lat, miss, mr);
    chk("R10", "slot 1 reg 7 independent", d, 32'hA100_0007);
    // R4: in-place update
    do_write(1, 7, 32'hA1FF_0007, 0, ev, evr, evd);
    chk("R4", "in-place write evicts nothing", 32'(ev), 32'd0);
    do_read(1, 7, d, lat, miss, mr);
    chk("R4", "in-place word", d, 32'hA1FF_0007);

    // R5: FIFO eviction with writeback in slot 3
    evc = 0;
    for (int r = 10; r <= 15; r++) begin
      do_write(3, r, d3(r), 0, ev, evr, evd);
      evc += int'(ev);
    end
    chk("R5", "fill group no eviction", evc, 0);
    do_write(3, 16, d3(16), 0, ev, evr, evd);
    chk("R5", "oldest evicted", 32'(ev), 32'd1);
    chk("R5", "victim register", 32'(evr), 32'd10);
    chk("R5", "victim word", evd, d3(10));
    do_read(3, 10, d, lat, miss, mr);
    chk("R5", "evicted reg misses", 32'(miss), 32'd1);
    chk("R5", "written-back word fetched", d, d3(10));

    // R7: flush slot 3; entries hold 16,10(clean),12..15
    @(negedge clk);
    flush = 1; flush_slot = 2'd3;
    wcnt = 0; flat = 0; first_reg = '0;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      flush = 0;
      if (bf_wr) begin
        if (wcnt == 0) first_reg = bf_wreg;
        wcnt++;
      end
      if (flush_done) begin flat = c; break; end
    end
    chk("R7", "flush writebacks", wcnt, 5);
    chk("R7", "first written back", 32'(first_reg), 32'd16);
    chk("R7", "done timing", flat, NE + 1);
    @(negedge clk);
    chk("R7", "done one cycle", 32'(flush_done), 32'd0);
    do_read(3, 16, d, lat, miss, mr);
    chk("R7", "flushed slot empty", 32'(miss), 32'd1);
    chk("R7", "flushed word in backing", d, d3(16));
    do_read(2, 63, d, lat, miss, mr);
    chk("R7", "other slot still hits", {31'd0, miss}, 32'd0);
    chk("R7", "other slot word", d, 32'hA200_003F);

    // R6: slot 3 holds 16 (clean) at entry 0
    do_write(3, 20, 32'hDEAD_0020, 1, ev, evr, evd);
    for (int r = 21; r <= 24; r++) do_write(3, r, d3(r), 0, ev, evr, evd);
    do_write(3, 25, d3(25), 0, ev, evr, evd);
    chk("R6", "clean victim no writeback", 32'(ev), 32'd0);
    do_write(3, 26, d3(26), 0, ev, evr, evd);
    chk("R6", "dead victim no writeback", 32'(ev), 32'd0);
    do_read(3, 20, d, lat, miss, mr);
    chk("R6", "backing kept old word", d, init_word(3, 20));

    // R8: write in the tag-check cycle of a read of an uncached register
    @(negedge clk);
    rd_req = 1; rd_slot = 2'd0; rd_reg = 6'd40;
    @(negedge clk);
    rd_req = 0;
    wr_en = 1; wr_slot = 2'd0; wr_reg = 6'd40; wr_data = 32'hF0F0_0040;
    #1;
    chk("R8", "no backing read", 32'(bf_rd), 32'd0);
    @(negedge clk);
    wr_en = 0;
    chk("R8", "ack", 32'(rd_ack), 32'd1);
    chk("R8", "forwarded word", rd_data, 32'hF0F0_0040);

    // R9: write held during a miss stall is ignored
    @(negedge clk);
    rd_req = 1; rd_slot = 2'd0; rd_reg = 6'd50;
    @(negedge clk);
    rd_req = 0;
    chk("R9", "stall on miss", 32'(stall), 32'd1);
    wr_en = 1; wr_slot = 2'd0; wr_reg = 6'd51; wr_data = 32'hBAD0_0051;
    @(negedge clk);
    chk("R3", "stall second cycle", 32'(stall), 32'd1);
    @(negedge clk);
    wr_en = 0;
    chk("R3", "miss ack", rd_data, init_word(0, 50));
    do_read(0, 51, d, lat, miss, mr);
    chk("R9", "stalled write dropped (miss)", 32'(miss), 32'd1);
    chk("R9", "stalled write dropped (word)", d, init_word(0, 51));

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule